// File: doc/BRIEF.md
# Vectored Interrupt Dispatcher

This block sits between the sources of interrupt requests and the instruction sequencer of a processor. It accepts three kinds of request: a non-maskable request from an external pin, a software interrupt or error trap raised by the execution unit, and a maskable external request. It picks one, reads that vector's four-word entry from a descriptor table in memory, and produces a single-cycle verdict. The verdict says whether to dispatch to a handler, ignore the request, reset the core, pause it, or halt it. A dispatch also supplies the new instruction pointer, the code segment, the comparison-register update, the parameter-register value and the last-vector record.

Each entry holds, in word order, the handler instruction pointer, the handler code segment, a reserved word and a flags word. Three flag bits decide what happens: the enable bit, the keep-segment bit and the report bit. A dispatch first pushes the return pointer and then the return segment through a stack-push port. A non-maskable request also raises a save-state strobe before the table is read.

The controller is a state machine. `ST_IDLE` accepts a request. It goes to `ST_DONE` when extended mode is off, to `ST_SAVE` for a non-maskable request, and to `ST_CHECK` otherwise. `ST_SAVE` raises the save strobe and moves to `ST_CHECK`. `ST_CHECK` goes to `ST_FETCH` when the vector is inside the size limit, and to `ST_DONE` when it is not. `ST_FETCH` starts the table reader and moves to `ST_WAIT`. When the last word has arrived, `ST_WAIT` goes to `ST_PUSH_IP` if the vector is handled and to `ST_DONE` if it is not. `ST_PUSH_IP` leads to `ST_PUSH_CS`, which leads to `ST_DONE`. `ST_DONE` pulses the result and returns to `ST_IDLE`.

Top module: `vec_irq_dispatch`

## Requirements
- R1: When several requests are pending in `ST_IDLE`, the non-maskable one wins, then the trap, then the maskable external one. At most one acknowledge is high in any cycle. Simultaneous requests are served one after another in that order.
- R2: While `int_en` is 0, a maskable external request is neither acknowledged nor lost. It is dispatched once `int_en` returns to 1.
- R3: A non-maskable request with a vector below 32 is acknowledged and discarded. It produces no save strobe, no table read and no `done` pulse.
- R4: A non-maskable request with a vector from 32 to 255 raises `nmi_save` for exactly one cycle before any table read. On dispatch, `parm_val` is 1 for a non-maskable request, the request's `trap_param` for a trap, and 0 for a maskable external request.
- R5: A table read issues four reads in consecutive cycles at `tbl_base + 4*vector + k`, for k = 0 to 3. Word 0 is the handler pointer, word 1 the handler segment and word 3 the flags.
- R6: A vector whose flags have bit 5 set is dispatched. The result has `out_kind` = 1, `new_ip` = word 0, `lint_we` = 1 and `lint_val` = the vector.
- R7: On dispatch, flag bit 4 clear gives `cs_load` = 1 and `new_cs` = word 1. Flag bit 4 set gives `cs_load` = 0 and `new_cs` = `ret_cs`.
- R8: When flag bit 3 is set, `cmpr_we` pulses with `done`. `cmpr_val` is then 1 if the vector was handled and all ones (-1) if it was not. When flag bit 3 is clear, `cmpr_we` stays 0.
- R9: When `tbl_limit` is nonzero and the vector is greater than or equal to it, the table is not read and the flags count as zero.
- R10: An unhandled vector 0 gives `out_kind` = 2 (reset). An unhandled vector 1 gives 3 (pause). Any other unhandled vector gives 0 (ignore).
- R11: With `ext_mode` = 0, no table read takes place. Vector 31 gives `out_kind` = 0, and every other vector gives 4 (halt).
- R12: A dispatch pushes `ret_ip` and then `ret_cs` in two consecutive `push_valid` cycles, immediately before `done`. Nothing is pushed for other outcomes.
- R13: After reset `done`, `mem_req`, `push_valid` and `nmi_save` are 0. Every accepted, non-discarded request yields exactly one single-cycle `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_req | input | 1 | Non-maskable request, held until acknowledged |
| nmi_vec | input | 8 | Non-maskable vector number |
| nmi_ack | output | 1 | Non-maskable request taken |
| trap_req | input | 1 | Software interrupt or error trap, held until acknowledged |
| trap_vec | input | 8 | Trap vector number |
| trap_param | input | WORD_W | Trap parameter |
| trap_ack | output | 1 | Trap taken |
| ext_req | input | 1 | Maskable external request, held until acknowledged |
| ext_vec | input | 8 | Maskable vector number |
| ext_ack | output | 1 | Maskable request taken |
| ext_mode | input | 1 | Extended mode; 0 makes requests halt |
| int_en | input | 1 | Enable for maskable requests |
| tbl_base | input | ADDR_W | Descriptor table base word address |
| tbl_limit | input | 9 | Table size limit in vectors; 0 means no limit |
| ret_ip | input | WORD_W | Return pointer to push |
| ret_cs | input | WORD_W | Return segment to push |
| mem_req | output | 1 | Table read strobe |
| mem_addr | output | ADDR_W | Table read word address |
| mem_rdata | input | WORD_W | Read data, one cycle after `mem_req` |
| nmi_save | output | 1 | Save full register state |
| push_valid | output | 1 | Stack push strobe |
| push_data | output | WORD_W | Word to push |
| done | output | 1 | Result valid |
| out_kind | output | 3 | 0 ignore, 1 dispatch, 2 reset, 3 pause, 4 halt |
| new_ip | output | WORD_W | Handler pointer |
| new_cs | output | WORD_W | Segment to run the handler in |
| cs_load | output | 1 | Segment taken from the entry |
| cmpr_we | output | 1 | Comparison register write |
| cmpr_val | output | WORD_W | 1 or -1 |
| parm_we | output | 1 | Parameter register write |
| parm_val | output | WORD_W | Parameter value |
| lint_we | output | 1 | Last-vector register write |
| lint_val | output | 8 | Vector dispatched |

## Verification
Some properties are checked by the assertions on every cycle. These are the mutual exclusion of the acknowledges, the masking of external requests, the address stepping and the four-beat length of a table read, the save strobe following a non-maskable acknowledge, the push that precedes every dispatch, the absence of reads before a halt, and the single-cycle `done` pulse. Other behaviour needs the bench's scoreboard scenarios. These cover the flag decoding into dispatch, ignore, reset and pause, the segment choice, the comparison value and the parameter choice per source. They also cover the size limit, the debug-vector exemption, the waiting of a masked request, the silent drop of low non-maskable vectors, and the order in which simultaneous requests are served.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
    localparam int VEC_W       = 8;
    localparam int ENTRY_WORDS = 4;
    localparam int BEAT_W      = $clog2(ENTRY_WORDS);
    localparam int W_IP        = 0;
    localparam int W_CS        = 1;
    localparam int W_FLAGS     = 3;
    localparam int FLG_REPORT  = 3;
    localparam int FLG_KEEPCS  = 4;
    localparam int FLG_EN      = 5;

    localparam logic [VEC_W-1:0] NMI_FIRST = 8'd32;
    localparam logic [VEC_W-1:0] DEBUG_VEC = 8'd31;
    localparam logic [VEC_W-1:0] VEC_RST   = 8'd0;
    localparam logic [VEC_W-1:0] VEC_PAUSE = 8'd1;

    typedef enum logic [2:0] {
        K_IGNORE   = 3'd0,
        K_DISPATCH = 3'd1,
        K_RESET    = 3'd2,
        K_PAUSE    = 3'd3,
        K_HALT     = 3'd4
    } kind_e;

    typedef enum logic [1:0] {
        SRC_NMI,
        SRC_TRAP,
        SRC_EXT
    } src_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAVE,
        ST_CHECK,
        ST_FETCH,
        ST_WAIT,
        ST_PUSH_IP,
        ST_PUSH_CS,
        ST_DONE
    } state_e;
endpackage

// File: rtl/irqd_req_sel.sv
module irqd_req_sel
    import irqd_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              nmi_req,
    input  logic [VEC_W-1:0]  nmi_vec,
    input  logic              trap_req,
    input  logic [VEC_W-1:0]  trap_vec,
    input  logic [WORD_W-1:0] trap_param,
    input  logic              ext_req,
    input  logic [VEC_W-1:0]  ext_vec,
    input  logic              int_en,
    output logic              grant,
    output logic              drop,
    output src_e              g_src,
    output logic [VEC_W-1:0]  g_vec,
    output logic [WORD_W-1:0] g_param,
    output logic              nmi_ack,
    output logic              trap_ack,
    output logic              ext_ack
);
    always_comb begin
        grant   = 1'b0;
        drop    = 1'b0;
        g_src   = SRC_TRAP;
        g_vec   = '0;
        g_param = '0;
        if (nmi_req) begin
            grant = 1'b1;
            g_src = SRC_NMI;
            g_vec = nmi_vec;
            drop  = (nmi_vec < NMI_FIRST);
        end else if (trap_req) begin
            grant   = 1'b1;
            g_src   = SRC_TRAP;
            g_vec   = trap_vec;
            g_param = trap_param;
        end else if (ext_req && int_en) begin
            grant = 1'b1;
            g_src = SRC_EXT;
            g_vec = ext_vec;
        end
    end

    assign nmi_ack  = take && grant && (g_src == SRC_NMI);
    assign trap_ack = take && grant && (g_src == SRC_TRAP);
    assign ext_ack  = take && grant && (g_src == SRC_EXT);

    assert_one_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nmi_ack, trap_ack, ext_ack}));

    assert_ext_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ack |-> int_en);
endmodule

// File: rtl/irqd_tbl_fetch.sv
module irqd_tbl_fetch
    import irqd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic [VEC_W-1:0]  vec,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] ent_ip,
    output logic [WORD_W-1:0] ent_cs,
    output logic [2:0]        ent_flags,
    output logic              done
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(ENTRY_WORDS - 1);

    logic              active;
    logic [BEAT_W-1:0] beat;
    logic              cap;
    logic [BEAT_W-1:0] cap_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            beat      <= '0;
            cap       <= 1'b0;
            cap_idx   <= '0;
            done      <= 1'b0;
            ent_ip    <= '0;
            ent_cs    <= '0;
            ent_flags <= '0;
        end else begin
            cap     <= active;
            cap_idx <= beat;
            done    <= cap && (cap_idx == LAST_BEAT);
            if (start) begin
                active <= 1'b1;
                beat   <= '0;
            end else if (active) begin
                beat <= beat + 1'b1;
                if (beat == LAST_BEAT) active <= 1'b0;
            end
            if (cap) begin
                if (cap_idx == BEAT_W'(W_IP))    ent_ip <= mem_rdata;
                if (cap_idx == BEAT_W'(W_CS))    ent_cs <= mem_rdata;
                if (cap_idx == BEAT_W'(W_FLAGS))
                    ent_flags <= {mem_rdata[FLG_EN], mem_rdata[FLG_KEEPCS], mem_rdata[FLG_REPORT]};
            end
        end
    end

    assign mem_req  = active;
    assign mem_addr = base + ADDR_W'({vec, beat});

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + 1'b1));

    assert_four_beats_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_req) |-> ($past(beat) == LAST_BEAT));
endmodule

// File: rtl/irqd_verdict.sv
module irqd_verdict
    import irqd_pkg::*;
(
    input  logic [VEC_W-1:0] vec,
    input  logic [2:0]       flags,
    input  logic             use_flags,
    output kind_e            kind,
    output logic             handled,
    output logic             keep_cs,
    output logic             report
);
    logic [2:0] fl;

    assign fl      = use_flags ? flags : 3'b000;
    assign handled = fl[2];
    assign keep_cs = fl[1];
    assign report  = fl[0];

    always_comb begin
        if (handled)                kind = K_DISPATCH;
        else if (vec == VEC_RST)    kind = K_RESET;
        else if (vec == VEC_PAUSE)  kind = K_PAUSE;
        else                        kind = K_IGNORE;
    end
endmodule

// File: rtl/vec_irq_dispatch.sv
module vec_irq_dispatch
    import irqd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_req,
    input  logic [7:0]        nmi_vec,
    output logic              nmi_ack,
    input  logic              trap_req,
    input  logic [7:0]        trap_vec,
    input  logic [WORD_W-1:0] trap_param,
    output logic              trap_ack,
    input  logic              ext_req,
    input  logic [7:0]        ext_vec,
    output logic              ext_ack,
    input  logic              ext_mode,
    input  logic              int_en,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [8:0]        tbl_limit,
    input  logic [WORD_W-1:0] ret_ip,
    input  logic [WORD_W-1:0] ret_cs,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              nmi_save,
    output logic              push_valid,
    output logic [WORD_W-1:0] push_data,
    output logic              done,
    output logic [2:0]        out_kind,
    output logic [WORD_W-1:0] new_ip,
    output logic [WORD_W-1:0] new_cs,
    output logic              cs_load,
    output logic              cmpr_we,
    output logic [WORD_W-1:0] cmpr_val,
    output logic              parm_we,
    output logic [WORD_W-1:0] parm_val,
    output logic              lint_we,
    output logic [7:0]        lint_val
);
    state_e state, nxt;

    logic              grant, drop;
    src_e              g_src;
    logic [VEC_W-1:0]  g_vec;
    logic [WORD_W-1:0] g_param;

    logic [VEC_W-1:0]  vec_q;
    logic [WORD_W-1:0] param_q, ip_q, cs_q;
    logic              nmi_q, cs_ld_q, cmpr_we_q, cmpr_neg_q;
    kind_e             kind_q;

    logic              f_start, f_done;
    logic [WORD_W-1:0] ent_ip, ent_cs;
    logic [2:0]        ent_flags;

    kind_e             v_kind;
    logic              v_handled, v_keep, v_report;
    logic              in_range;

    irqd_req_sel #(.WORD_W(WORD_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .take(state == ST_IDLE),
        .nmi_req(nmi_req), .nmi_vec(nmi_vec),
        .trap_req(trap_req), .trap_vec(trap_vec), .trap_param(trap_param),
        .ext_req(ext_req), .ext_vec(ext_vec), .int_en(int_en),
        .grant(grant), .drop(drop), .g_src(g_src), .g_vec(g_vec), .g_param(g_param),
        .nmi_ack(nmi_ack), .trap_ack(trap_ack), .ext_ack(ext_ack)
    );

    irqd_tbl_fetch #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .start(f_start), .base(tbl_base), .vec(vec_q),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .ent_ip(ent_ip), .ent_cs(ent_cs), .ent_flags(ent_flags), .done(f_done)
    );

    irqd_verdict u_verdict (
        .vec(vec_q), .flags(ent_flags), .use_flags(state == ST_WAIT),
        .kind(v_kind), .handled(v_handled), .keep_cs(v_keep), .report(v_report)
    );

    assign in_range = (tbl_limit == '0) || ({1'b0, vec_q} < tbl_limit);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (grant && !drop) begin
                    if (!ext_mode)              nxt = ST_DONE;
                    else if (g_src == SRC_NMI)  nxt = ST_SAVE;
                    else                        nxt = ST_CHECK;
                end
            end
            ST_SAVE:    nxt = ST_CHECK;
            ST_CHECK:   nxt = in_range ? ST_FETCH : ST_DONE;
            ST_FETCH:   nxt = ST_WAIT;
            ST_WAIT:    if (f_done) nxt = v_handled ? ST_PUSH_IP : ST_DONE;
            ST_PUSH_IP: nxt = ST_PUSH_CS;
            ST_PUSH_CS: nxt = ST_DONE;
            ST_DONE:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // request context and verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q      <= '0;
            param_q    <= '0;
            nmi_q      <= 1'b0;
            kind_q     <= K_IGNORE;
            ip_q       <= '0;
            cs_q       <= '0;
            cs_ld_q    <= 1'b0;
            cmpr_we_q  <= 1'b0;
            cmpr_neg_q <= 1'b0;
        end else begin
            if (state == ST_IDLE && grant && !drop) begin
                vec_q     <= g_vec;
                param_q   <= g_param;
                nmi_q     <= (g_src == SRC_NMI);
                cs_ld_q   <= 1'b0;
                cmpr_we_q <= 1'b0;
                kind_q    <= (g_vec == DEBUG_VEC) ? K_IGNORE : K_HALT;
            end
            if (state == ST_CHECK && !in_range) begin
                kind_q     <= v_kind;
                cmpr_we_q  <= v_report;
                cmpr_neg_q <= !v_handled;
            end
            if (state == ST_WAIT && f_done) begin
                kind_q     <= v_kind;
                cmpr_we_q  <= v_report;
                cmpr_neg_q <= !v_handled;
                ip_q       <= ent_ip;
                cs_q       <= ent_cs;
                cs_ld_q    <= v_handled && !v_keep;
            end
        end
    end

    // outputs
    always_comb begin
        f_start    = (state == ST_FETCH);
        nmi_save   = (state == ST_SAVE);
        push_valid = (state == ST_PUSH_IP) || (state == ST_PUSH_CS);
        push_data  = (state == ST_PUSH_CS) ? ret_cs : ret_ip;
        done       = (state == ST_DONE);
        out_kind   = done ? kind_q : K_IGNORE;
        new_ip     = ip_q;
        new_cs     = cs_ld_q ? cs_q : ret_cs;
        cs_load    = done && cs_ld_q;
        cmpr_we    = done && cmpr_we_q;
        cmpr_val   = cmpr_neg_q ? '1 : WORD_W'(1);
        parm_we    = done && (kind_q == K_DISPATCH);
        parm_val   = nmi_q ? WORD_W'(1) : param_q;
        lint_we    = parm_we;
        lint_val   = vec_q;
    end

    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_push_before_jump_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && out_kind == K_DISPATCH) |-> $past(push_valid));

    assert_save_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_save |-> $past(nmi_ack));

    assert_halt_no_fetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && out_kind == K_HALT) |-> !$past(mem_req));
endmodule

// File: tb/vec_irq_dispatch_test.sv
module vec_irq_dispatch_test;
    import irqd_pkg::*;

    localparam int CLK_P = 10;
    localparam int W     = 32;
    localparam int AW    = 32;
    localparam logic [AW-1:0] BASE = 32'd512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nmi_req = 0, trap_req = 0, ext_req = 0;
    logic [7:0] nmi_vec = 0, trap_vec = 0, ext_vec = 0;
    logic [W-1:0] trap_param = 0;
    logic ext_mode = 1, int_en = 1;
    logic [8:0] tbl_limit = 0;
    logic [W-1:0] ret_ip = 32'h1234, ret_cs = 32'h55;
    logic [W-1:0] mem_rdata = 0;
    logic nmi_ack, trap_ack, ext_ack, mem_req, nmi_save, push_valid, done;
    logic cs_load, cmpr_we, parm_we, lint_we;
    logic [AW-1:0] mem_addr;
    logic [W-1:0] push_data, new_ip, new_cs, cmpr_val, parm_val;
    logic [2:0] out_kind;
    logic [7:0] lint_val;

    always #(CLK_P/2) clk = ~clk;

    vec_irq_dispatch #(.ADDR_W(AW), .WORD_W(W)) uut (
        .clk(clk), .rst_n(rst_n),
        .nmi_req(nmi_req), .nmi_vec(nmi_vec), .nmi_ack(nmi_ack),
        .trap_req(trap_req), .trap_vec(trap_vec), .trap_param(trap_param), .trap_ack(trap_ack),
        .ext_req(ext_req), .ext_vec(ext_vec), .ext_ack(ext_ack),
        .ext_mode(ext_mode), .int_en(int_en), .tbl_base(BASE), .tbl_limit(tbl_limit),
        .ret_ip(ret_ip), .ret_cs(ret_cs),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .nmi_save(nmi_save), .push_valid(push_valid), .push_data(push_data),
        .done(done), .out_kind(out_kind), .new_ip(new_ip), .new_cs(new_cs), .cs_load(cs_load),
        .cmpr_we(cmpr_we), .cmpr_val(cmpr_val), .parm_we(parm_we), .parm_val(parm_val),
        .lint_we(lint_we), .lint_val(lint_val)
    );

    logic [W-1:0] mem [0:2047];
    logic [W-1:0] t_ip [0:255];
    logic [W-1:0] t_cs [0:255];
    logic [W-1:0] t_fl [0:255];

    always @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr[10:0]];

    typedef struct {
        logic [2:0]  kind;
        logic [W-1:0] ip, cs, cmpr, parm;
        logic        cs_load, cmpr_we;
        logic [7:0]  lint;
        int          n_push, n_save, n_fetch;
        logic [AW-1:0] addr0;
        string       tag;
    } exp_t;

    exp_t sb[$];
    logic [W-1:0] pushed[$];
    int total = 0, fails = 0;
    int done_cnt = 0, s_cnt = 0, f_cnt = 0, ext_ack_cnt = 0;
    logic [AW-1:0] f_addr0 = 0;
    bit finished = 0;

    task automatic chk(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_entry(int v, logic [W-1:0] ip, logic [W-1:0] cs, logic [W-1:0] fl);
        mem[BASE + v*4 + 0] = ip;
        mem[BASE + v*4 + 1] = cs;
        mem[BASE + v*4 + 2] = 0;
        mem[BASE + v*4 + 3] = fl;
        t_ip[v] = ip; t_cs[v] = cs; t_fl[v] = fl;
    endtask

    function automatic exp_t predict(src_e s, logic [7:0] v, logic [W-1:0] p, string tag);
        exp_t e;
        logic [W-1:0] fl;
        bit inr, hnd;
        e.tag = tag; e.ip = 0; e.cs = 0; e.cmpr = 0; e.parm = 0; e.lint = v;
        e.cs_load = 0; e.cmpr_we = 0; e.n_push = 0; e.n_save = 0; e.n_fetch = 0;
        e.addr0 = BASE + v*4;
        if (!ext_mode) begin
            e.kind = (v == 8'd31) ? 3'd0 : 3'd4;
            return e;
        end
        e.n_save = (s == SRC_NMI) ? 1 : 0;
        inr = (tbl_limit == 0) || ({1'b0, v} < tbl_limit);
        e.n_fetch = inr ? 4 : 0;
        fl = inr ? t_fl[v] : 0;
        hnd = fl[5];
        e.kind = hnd ? 3'd1 : (v == 0) ? 3'd2 : (v == 1) ? 3'd3 : 3'd0;
        e.cmpr_we = fl[3];
        e.cmpr = hnd ? 32'd1 : 32'hFFFF_FFFF;
        e.n_push = hnd ? 2 : 0;
        e.ip = t_ip[v];
        e.cs_load = hnd && !fl[4];
        e.cs = fl[4] ? ret_cs : t_cs[v];
        e.parm = (s == SRC_NMI) ? 32'd1 : (s == SRC_EXT) ? 32'd0 : p;
        return e;
    endfunction

    always @(posedge clk) if (rst_n && ext_ack) ext_ack_cnt++;

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req) begin
                if (f_cnt == 0) f_addr0 = mem_addr;
                f_cnt++;
            end
            if (nmi_save) s_cnt++;
            if (push_valid) pushed.push_back(push_data);
            if (done) begin
                done_cnt++;
                if (sb.size() == 0) begin
                    chk(0, "R13 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(out_kind == e.kind, {e.tag, " out_kind"}, W'(out_kind), W'(e.kind));
                    chk(f_cnt == e.n_fetch, "R5 read count", f_cnt, e.n_fetch);
                    if (e.n_fetch != 0) chk(f_addr0 == e.addr0, "R5 first address", f_addr0, e.addr0);
                    chk(s_cnt == e.n_save, "R4 save strobes", s_cnt, e.n_save);
                    chk(pushed.size() == e.n_push, "R12 push count", pushed.size(), e.n_push);
                    if (e.n_push == 2 && pushed.size() == 2) begin
                        chk(pushed[0] == ret_ip, "R12 first push", pushed[0], ret_ip);
                        chk(pushed[1] == ret_cs, "R12 second push", pushed[1], ret_cs);
                    end
                    chk(cmpr_we == e.cmpr_we, "R8 cmpr_we", W'(cmpr_we), W'(e.cmpr_we));
                    if (e.cmpr_we) chk(cmpr_val == e.cmpr, "R8 cmpr_val", cmpr_val, e.cmpr);
                    chk(parm_we == (e.kind == 3'd1), "R6 parm_we", W'(parm_we), W'(e.kind == 3'd1));
                    if (e.kind == 3'd1) begin
                        chk(new_ip == e.ip, "R6 new_ip", new_ip, e.ip);
                        chk(lint_we && lint_val == e.lint, "R6 lint", W'(lint_val), W'(e.lint));
                        chk(cs_load == e.cs_load, "R7 cs_load", W'(cs_load), W'(e.cs_load));
                        chk(new_cs == e.cs, "R7 new_cs", new_cs, e.cs);
                        chk(parm_val == e.parm, "R4 parm_val", parm_val, e.parm);
                    end
                end
                pushed.delete();
                s_cnt = 0;
                f_cnt = 0;
            end
        end
    end

    task automatic fire_trap(logic [7:0] v, logic [W-1:0] p);
        bit got = 0;
        @(negedge clk);
        trap_vec = v; trap_param = p; trap_req = 1;
        while (!got) begin
            #(CLK_P/4);
            got = trap_ack;
            if (!got) @(negedge clk);
        end
        @(negedge clk);
        trap_req = 0;
    endtask

    task automatic fire_nmi(logic [7:0] v);
        bit got = 0;
        @(negedge clk);
        nmi_vec = v; nmi_req = 1;
        while (!got) begin
            #(CLK_P/4);
            got = nmi_ack;
            if (!got) @(negedge clk);
        end
        @(negedge clk);
        nmi_req = 0;
    endtask

    task automatic trap_case(logic [7:0] v, logic [W-1:0] p, string tag);
        sb.push_back(predict(SRC_TRAP, v, p, tag));
        fire_trap(v, p);
        settle();
    endtask

    task automatic settle();
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
        end
    end

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = 0;
        for (int i = 0; i < 256; i++) begin t_ip[i] = 0; t_cs[i] = 0; t_fl[i] = 0; end
        set_entry(5,  32'h400, 32'h20, 32'd32);
        set_entry(6,  32'h410, 32'h21, 32'd48);
        set_entry(7,  32'h420, 32'h22, 32'd40);
        set_entry(8,  32'h430, 32'h23, 32'd8);
        set_entry(0,  32'h440, 32'h24, 32'd0);
        set_entry(1,  32'h450, 32'h25, 32'd8);
        set_entry(12, 32'h460, 32'h26, 32'd40);
        set_entry(9,  32'h470, 32'h27, 32'd32);
        set_entry(40, 32'h500, 32'h30, 32'd32);
        set_entry(50, 32'h600, 32'h31, 32'd32);

        repeat (3) @(negedge clk);
        chk(!done && !mem_req && !push_valid && !nmi_save, "R13 reset outputs",
            W'({done, mem_req, push_valid, nmi_save}), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        trap_case(8'd5, 32'h77, "R6 enabled dispatch");
        trap_case(8'd6, 32'h78, "R7 keep segment");
        trap_case(8'd7, 32'h79, "R8 handled report");
        trap_case(8'd8, 32'h7A, "R8 unhandled report");
        trap_case(8'd0, 32'h0,  "R10 vector 0 reset");
        trap_case(8'd1, 32'h0,  "R10 vector 1 pause");

        tbl_limit = 9'd10;
        trap_case(8'd12, 32'h1, "R9 beyond limit");
        trap_case(8'd9,  32'h2, "R9 inside limit");
        tbl_limit = 9'd0;

        ext_mode = 0;
        trap_case(8'd5,  32'h3, "R11 halt");
        trap_case(8'd31, 32'h4, "R11 debug vector");
        ext_mode = 1;

        sb.push_back(predict(SRC_NMI, 8'd40, 0, "R4 nmi dispatch"));
        fire_nmi(8'd40);
        settle();

        begin
            int d0;
            d0 = done_cnt;
            s_cnt = 0;
            fire_nmi(8'd10);
            repeat (10) @(negedge clk);
            chk(done_cnt == d0, "R3 low nmi no done", done_cnt, d0);
            chk(s_cnt == 0, "R3 low nmi no save", s_cnt, 0);
            chk(f_cnt == 0, "R3 low nmi no read", f_cnt, 0);
        end

        begin
            int d0;
            bit got = 0;
            d0 = done_cnt;
            int_en = 0;
            @(negedge clk);
            ext_vec = 8'd50; ext_req = 1;
            repeat (20) @(negedge clk);
            chk(ext_ack_cnt == 0, "R2 masked not taken", ext_ack_cnt, 0);
            chk(done_cnt == d0, "R2 masked no done", done_cnt, d0);
            sb.push_back(predict(SRC_EXT, 8'd50, 0, "R2 masked later dispatch"));
            int_en = 1;
            while (!got) begin
                #(CLK_P/4);
                got = ext_ack;
                if (!got) @(negedge clk);
            end
            @(negedge clk);
            ext_req = 0;
            settle();
            chk(ext_ack_cnt == 1, "R2 single ack", ext_ack_cnt, 1);
        end

        sb.push_back(predict(SRC_NMI, 8'd40, 0, "R1 nmi first"));
        sb.push_back(predict(SRC_TRAP, 8'd9, 32'h99, "R1 trap second"));
        fork
            fire_nmi(8'd40);
            fire_trap(8'd9, 32'h99);
        join
        settle();

        chk(sb.size() == 0, "R13 all results seen", sb.size(), 0);
        finished = 1;
        summary();
    end
endmodule